// File: doc/BRIEF.md
# Masked Write Buffer Retire Controller

This block sits between a column command decoder and a bank/column storage array. It holds one pending write of a 16-byte unit, split into a 64-bit half A and a 64-bit half B, together with the bank and column the write targets. The write is not committed when its command arrives. It is retired into the array by a later column command, and that command must be one that leaves the internal data path free. Byte masks for a buffered write come in on a separate strobe, several cycles after the write itself.

Each cycle the block may receive one decoded column command. The command carries an operation code, a flag that says whether it targets this device, and a bank and column address. Write data arrives together with write commands. In response the block drives three things: a retire write port with a per-byte enable, a read request port, and a per-bank precharge pulse vector.

Top module: `wbr_retire_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it is released, `ret_we`, `rd_en` and `pre_banks` are all zero, and the buffer is empty: a local NOCOP issued right after reset produces no retire strobe.
- R2: A local WR (op 1) retires any write already held, then stores its own data, bank and column. The retire strobe appears on the first clock edge after the command and carries the older write's bank, column and data. The new write is retired by a later command.
- R3: When the buffer is empty, a retire opportunity does nothing. When the buffer is full, a retire opportunity produces exactly one `ret_we` pulse and empties the buffer. Back-to-back pulses can happen only when a local WR or WRA loaded the buffer in between.
- R4: Any valid command whose `cmd_hit` is 0 allows a retire, whatever its op code. A local NOCOP (op 0) also allows a retire. A WR addressed to another device does not load the buffer and raises no read request.
- R5: A local RD (op 2) or RDA (op 5) never retires the buffer; the buffer stays full until a later command allows it. On the next clock edge such a command drives `rd_en` high, with `rd_bank` and `rd_col` equal to the command's address.
- R6: Mask encoding: a mask bit of 1 writes and 0 skips. Bit i of `mask_a` enables byte i of half A, meaning `wr_data_a[8i+7:8i]`; byte 0 is the earliest. `mask_b` does the same for half B. The mask used at a retire is taken in this order: the mask presented on that same cycle; otherwise the last mask received while the write was buffered; otherwise all ones.
- R7: A `mask_valid` strobe that arrives while the buffer is empty is ignored. The next write is retired with all-ones masks unless a mask arrives for it.
- R8: A mask strobe never arrives fewer than `MIN_MASK_GAP` (default 8) cycles after the last local WR or WRA.
- R9: A local PREC (op 3) retires the buffer if it is full. Two clock edges after the command it sets the bit of `pre_banks` indexed by the command's bank, which is one cycle after the retire strobe.
- R10: A local WRA (op 4) behaves like WR. In addition, when its own data is later retired, the bit of `pre_banks` for its bank is set on the clock edge after that retire strobe.
- R11: A local RDA raises the read request like RD. Two clock edges after the command it sets the bit of `pre_banks` for the command's bank.
- R12: A cycle with `cmd_valid` low, or a local command with a reserved op (6 or 7), has no effect: no retire, no read, no precharge, and no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A column command is present this cycle |
| cmd_hit | input | 1 | The command addresses this device |
| cmd_op | input | 3 | Op code: 0 NOCOP, 1 WR, 2 RD, 3 PREC, 4 WRA, 5 RDA, 6/7 reserved |
| cmd_bank | input | BANK_W | Bank address of the command |
| cmd_col | input | COL_W | Column address of the command |
| wr_data_a | input | HALF_W | Write data, half A |
| wr_data_b | input | HALF_W | Write data, half B |
| mask_valid | input | 1 | Byte masks present this cycle |
| mask_a | input | HALF_W/8 | Byte enables for half A |
| mask_b | input | HALF_W/8 | Byte enables for half B |
| ret_we | output | 1 | Retire write strobe to the storage array |
| ret_bank | output | BANK_W | Bank of the retired write |
| ret_col | output | COL_W | Column of the retired write |
| ret_data_a | output | HALF_W | Retired data, half A |
| ret_data_b | output | HALF_W | Retired data, half B |
| ret_mask_a | output | HALF_W/8 | Byte enables of the retired write, half A |
| ret_mask_b | output | HALF_W/8 | Byte enables of the retired write, half B |
| rd_en | output | 1 | Read request to the storage array |
| rd_bank | output | BANK_W | Read bank |
| rd_col | output | COL_W | Read column |
| pre_banks | output | 2**BANK_W | One pulse bit per bank to precharge |

## Verification
The checker watches several properties on every cycle:
- no retire strobe ever follows a local read, and a retire appears only after a valid command;
- back-to-back retires need an intervening load;
- the read port follows local reads;
- precharges from PREC and RDA land on the right bank two edges later;
- no mask arrives closer to a write than the minimum gap.

Other behaviour needs the bench's scenarios, because it depends on what the buffer held earlier. That covers which older write a WR retires, whether a blocked write is later committed with its stored mask, that a stray mask on an empty buffer is dropped, and that a WRA precharge waits for the retire of its own data.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef enum logic [2:0] {
    OP_NOCOP = 3'd0,
    OP_WR    = 3'd1,
    OP_RD    = 3'd2,
    OP_PREC  = 3'd3,
    OP_WRA   = 3'd4,
    OP_RDA   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } col_op_e;
endpackage

// File: rtl/wbr_cmd_decode.sv
module wbr_cmd_decode
  import wbr_pkg::*;
(
  input  logic       cmd_valid,
  input  logic       cmd_hit,
  input  logic [2:0] cmd_op,
  output logic       retire_ok,
  output logic       load_wr,
  output logic       load_auto,
  output logic       read_req,
  output logic       pre_cmd
);
  col_op_e op;
  logic    local_cmd;
  logic    foreign_cmd;

  always_comb begin
    op          = col_op_e'(cmd_op);
    local_cmd   = cmd_valid & cmd_hit;
    foreign_cmd = cmd_valid & ~cmd_hit;
    retire_ok   = foreign_cmd |
                  (local_cmd & ((op == OP_NOCOP) | (op == OP_WR) |
                                (op == OP_WRA)   | (op == OP_PREC)));
    load_wr     = local_cmd & ((op == OP_WR) | (op == OP_WRA));
    load_auto   = local_cmd & (op == OP_WRA);
    read_req    = local_cmd & ((op == OP_RD) | (op == OP_RDA));
    pre_cmd     = local_cmd & ((op == OP_PREC) | (op == OP_RDA));
  end
endmodule

// File: rtl/wbr_buffer.sv
module wbr_buffer #(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int HALF_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          retire_ok,
  input  logic                          load_wr,
  input  logic                          load_auto,
  input  logic [BANK_W-1:0]             cmd_bank,
  input  logic [COL_W-1:0]              cmd_col,
  input  logic [1:0][HALF_W-1:0]        wr_data,
  input  logic                          mask_valid,
  input  logic [1:0][HALF_W/8-1:0]      mask_in,
  output logic                          retire,
  output logic [BANK_W-1:0]             buf_bank,
  output logic [COL_W-1:0]              buf_col,
  output logic [1:0][HALF_W-1:0]        buf_data,
  output logic [1:0][HALF_W/8-1:0]      eff_mask,
  output logic                          buf_auto
);
  localparam int BYTES = HALF_W / 8;

  logic                   valid_q, valid_d;
  logic                   mask_en;
  logic [1:0][BYTES-1:0]  mask_q, mask_d;
  logic [BANK_W-1:0]      bank_q;
  logic [COL_W-1:0]       col_q;
  logic                   auto_q;
  logic [1:0][HALF_W-1:0] data_q;

  always_comb begin
    retire  = valid_q & retire_ok;
    valid_d = load_wr | (valid_q & ~retire);
    mask_en = load_wr | (mask_valid & valid_q);
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      mask_d[h]   = load_wr ? {BYTES{1'b1}} : mask_in[h];
      eff_mask[h] = mask_valid ? mask_in[h] : mask_q[h];
    end

    always_ff @(posedge clk) begin
      if (load_wr) data_q[h] <= wr_data[h];
      if (mask_en) mask_q[h] <= mask_d[h];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_wr) begin
      bank_q <= cmd_bank;
      col_q  <= cmd_col;
      auto_q <= load_auto;
    end
  end

  assign buf_bank = bank_q;
  assign buf_col  = col_q;
  assign buf_data = data_q;
  assign buf_auto = auto_q;
endmodule

// File: rtl/wbr_issue.sv
module wbr_issue #(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int HALF_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          retire,
  input  logic [BANK_W-1:0]             buf_bank,
  input  logic [COL_W-1:0]              buf_col,
  input  logic [1:0][HALF_W-1:0]        buf_data,
  input  logic [1:0][HALF_W/8-1:0]      eff_mask,
  input  logic                          buf_auto,
  input  logic                          read_req,
  input  logic                          pre_cmd,
  input  logic [BANK_W-1:0]             cmd_bank,
  input  logic [COL_W-1:0]              cmd_col,
  output logic                          ret_we,
  output logic [BANK_W-1:0]             ret_bank,
  output logic [COL_W-1:0]              ret_col,
  output logic [1:0][HALF_W-1:0]        ret_data,
  output logic [1:0][HALF_W/8-1:0]      ret_mask,
  output logic                          rd_en,
  output logic [BANK_W-1:0]             rd_bank,
  output logic [COL_W-1:0]              rd_col,
  output logic [(1<<BANK_W)-1:0]        pre_banks
);
  localparam int NBANK = 1 << BANK_W;

  logic                 ret_we_q, rd_en_q;
  logic                 pcmd1_q, auto1_q;
  logic [BANK_W-1:0]    pbank1_q;
  logic [BANK_W-1:0]    ret_bank_q;
  logic [NBANK-1:0]     pre_q, pre_d;

  always_comb begin
    pre_d = '0;
    if (pcmd1_q) pre_d = pre_d | (NBANK'(1) << pbank1_q);
    if (auto1_q) pre_d = pre_d | (NBANK'(1) << ret_bank_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_we_q <= 1'b0;
      rd_en_q  <= 1'b0;
      pcmd1_q  <= 1'b0;
      auto1_q  <= 1'b0;
      pre_q    <= '0;
    end else begin
      ret_we_q <= retire;
      rd_en_q  <= read_req;
      pcmd1_q  <= pre_cmd;
      auto1_q  <= retire & buf_auto;
      pre_q    <= pre_d;
    end
  end

  always_ff @(posedge clk) begin
    if (retire) begin
      ret_bank_q <= buf_bank;
      ret_col    <= buf_col;
      ret_data   <= buf_data;
      ret_mask   <= eff_mask;
    end
    if (read_req) begin
      rd_bank <= cmd_bank;
      rd_col  <= cmd_col;
    end
    if (pre_cmd) pbank1_q <= cmd_bank;
  end

  assign ret_we    = ret_we_q;
  assign ret_bank  = ret_bank_q;
  assign rd_en     = rd_en_q;
  assign pre_banks = pre_q;
endmodule

// File: rtl/wbr_retire_ctrl.sv
module wbr_retire_ctrl #(
  parameter int BANK_W       = 5,
  parameter int COL_W        = 6,
  parameter int HALF_W       = 64,
  parameter int MIN_MASK_GAP = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_hit,
  input  logic [2:0]              cmd_op,
  input  logic [BANK_W-1:0]       cmd_bank,
  input  logic [COL_W-1:0]        cmd_col,
  input  logic [HALF_W-1:0]       wr_data_a,
  input  logic [HALF_W-1:0]       wr_data_b,
  input  logic                    mask_valid,
  input  logic [HALF_W/8-1:0]     mask_a,
  input  logic [HALF_W/8-1:0]     mask_b,
  output logic                    ret_we,
  output logic [BANK_W-1:0]       ret_bank,
  output logic [COL_W-1:0]        ret_col,
  output logic [HALF_W-1:0]       ret_data_a,
  output logic [HALF_W-1:0]       ret_data_b,
  output logic [HALF_W/8-1:0]     ret_mask_a,
  output logic [HALF_W/8-1:0]     ret_mask_b,
  output logic                    rd_en,
  output logic [BANK_W-1:0]       rd_bank,
  output logic [COL_W-1:0]        rd_col,
  output logic [(1<<BANK_W)-1:0]  pre_banks
);
  localparam int BYTES = HALF_W / 8;

  logic                   retire_ok, load_wr, load_auto, read_req, pre_cmd;
  logic                   retire, buf_auto;
  logic [BANK_W-1:0]      buf_bank;
  logic [COL_W-1:0]       buf_col;
  logic [1:0][HALF_W-1:0] wr_data, buf_data, ret_data;
  logic [1:0][BYTES-1:0]  mask_in, eff_mask, ret_mask;

  assign wr_data    = {wr_data_b, wr_data_a};
  assign mask_in    = {mask_b, mask_a};
  assign ret_data_a = ret_data[0];
  assign ret_data_b = ret_data[1];
  assign ret_mask_a = ret_mask[0];
  assign ret_mask_b = ret_mask[1];

  wbr_cmd_decode i_dec (
    .cmd_valid (cmd_valid),
    .cmd_hit   (cmd_hit),
    .cmd_op    (cmd_op),
    .retire_ok (retire_ok),
    .load_wr   (load_wr),
    .load_auto (load_auto),
    .read_req  (read_req),
    .pre_cmd   (pre_cmd)
  );

  wbr_buffer #(.BANK_W(BANK_W), .COL_W(COL_W), .HALF_W(HALF_W)) i_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_ok  (retire_ok),
    .load_wr    (load_wr),
    .load_auto  (load_auto),
    .cmd_bank   (cmd_bank),
    .cmd_col    (cmd_col),
    .wr_data    (wr_data),
    .mask_valid (mask_valid),
    .mask_in    (mask_in),
    .retire     (retire),
    .buf_bank   (buf_bank),
    .buf_col    (buf_col),
    .buf_data   (buf_data),
    .eff_mask   (eff_mask),
    .buf_auto   (buf_auto)
  );

  wbr_issue #(.BANK_W(BANK_W), .COL_W(COL_W), .HALF_W(HALF_W)) i_iss (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .buf_bank  (buf_bank),
    .buf_col   (buf_col),
    .buf_data  (buf_data),
    .eff_mask  (eff_mask),
    .buf_auto  (buf_auto),
    .read_req  (read_req),
    .pre_cmd   (pre_cmd),
    .cmd_bank  (cmd_bank),
    .cmd_col   (cmd_col),
    .ret_we    (ret_we),
    .ret_bank  (ret_bank),
    .ret_col   (ret_col),
    .ret_data  (ret_data),
    .ret_mask  (ret_mask),
    .rd_en     (rd_en),
    .rd_bank   (rd_bank),
    .rd_col    (rd_col),
    .pre_banks (pre_banks)
  );
endmodule

// File: rtl/wbr_retire_chk.sv
module wbr_retire_chk
  import wbr_pkg::*;
#(
  parameter int BANK_W       = 5,
  parameter int COL_W        = 6,
  parameter int HALF_W       = 64,
  parameter int MIN_MASK_GAP = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_hit,
  input logic [2:0]              cmd_op,
  input logic [BANK_W-1:0]       cmd_bank,
  input logic [COL_W-1:0]        cmd_col,
  input logic [HALF_W-1:0]       wr_data_a,
  input logic [HALF_W-1:0]       wr_data_b,
  input logic                    mask_valid,
  input logic [HALF_W/8-1:0]     mask_a,
  input logic [HALF_W/8-1:0]     mask_b,
  input logic                    ret_we,
  input logic [BANK_W-1:0]       ret_bank,
  input logic [COL_W-1:0]        ret_col,
  input logic [HALF_W-1:0]       ret_data_a,
  input logic [HALF_W-1:0]       ret_data_b,
  input logic [HALF_W/8-1:0]     ret_mask_a,
  input logic [HALF_W/8-1:0]     ret_mask_b,
  input logic                    rd_en,
  input logic [BANK_W-1:0]       rd_bank,
  input logic [COL_W-1:0]        rd_col,
  input logic [(1<<BANK_W)-1:0]  pre_banks
);
  localparam int GAP_W = $clog2(MIN_MASK_GAP + 1) + 1;

  logic             loc_read, loc_write, loc_prec, loc_rda;
  logic [GAP_W-1:0] gap_cnt;
  logic             wr_seen;

  assign loc_read  = cmd_valid && cmd_hit && (cmd_op == OP_RD || cmd_op == OP_RDA);
  assign loc_write = cmd_valid && cmd_hit && (cmd_op == OP_WR || cmd_op == OP_WRA);
  assign loc_prec  = cmd_valid && cmd_hit && (cmd_op == OP_PREC);
  assign loc_rda   = cmd_valid && cmd_hit && (cmd_op == OP_RDA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      wr_seen <= 1'b0;
    end else if (loc_write) begin
      gap_cnt <= GAP_W'(1);
      wr_seen <= 1'b1;
    end else if (gap_cnt < GAP_W'(MIN_MASK_GAP)) begin
      gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  AST_NO_LOCAL_READ_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    loc_read |=> !ret_we); // R5
  AST_READ_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    loc_read |=> (rd_en && rd_bank == $past(cmd_bank) && rd_col == $past(cmd_col))); // R5
  AST_RETIRE_NEEDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we |-> $past(cmd_valid)); // R12
  AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_we && $past(ret_we)) |-> $past(loc_write, 2)); // R3
  AST_PREC_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loc_prec, 2) |-> pre_banks[$past(cmd_bank, 2)]); // R9
  AST_RDA_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loc_rda, 2) |-> pre_banks[$past(cmd_bank, 2)]); // R11
  AST_MASK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_valid && wr_seen) |-> (gap_cnt >= GAP_W'(MIN_MASK_GAP))); // R8
endmodule

bind wbr_retire_ctrl wbr_retire_chk #(
  .BANK_W(BANK_W), .COL_W(COL_W), .HALF_W(HALF_W), .MIN_MASK_GAP(MIN_MASK_GAP)
) i_chk (.*);

// File: tb/test_wbr_retire_ctrl.sv
module test_wbr_retire_ctrl;
  localparam int BANK_W = 5;
  localparam int COL_W  = 6;
  localparam int HALF_W = 64;
  localparam int NB     = 1 << BANK_W;

  logic clk, rst_n;
  logic cmd_valid, cmd_hit, mask_valid;
  logic [2:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0] cmd_col;
  logic [HALF_W-1:0] wr_data_a, wr_data_b;
  logic [7:0] mask_a, mask_b;
  logic ret_we, rd_en;
  logic [BANK_W-1:0] ret_bank, rd_bank;
  logic [COL_W-1:0] ret_col, rd_col;
  logic [HALF_W-1:0] ret_data_a, ret_data_b;
  logic [7:0] ret_mask_a, ret_mask_b;
  logic [NB-1:0] pre_banks;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  wbr_retire_ctrl i_wbr_retire_ctrl (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drives one command for one cycle; returns at the negedge after it is sampled
  task automatic issue(input logic vld, input logic [2:0] op, input logic hit,
                       input int bank, input int col,
                       input logic [63:0] da, input logic [63:0] db,
                       input logic mv, input logic [7:0] ma, input logic [7:0] mb);
    cmd_valid  = vld;  cmd_op = op;  cmd_hit = hit;
    cmd_bank   = BANK_W'(bank);  cmd_col = COL_W'(col);
    wr_data_a  = da;  wr_data_b = db;
    mask_valid = mv;  mask_a = ma;  mask_b = mb;
    @(negedge clk);
    cmd_valid  = 1'b0;  mask_valid = 1'b0;
  endtask

  task automatic chk_ret(input string req, input int bank, input int col,
                         input logic [63:0] da, input logic [63:0] db,
                         input logic [7:0] ma, input logic [7:0] mb);
    chk(req, "ret_we", ret_we, 1);
    chk(req, "ret_bank", ret_bank, bank);
    chk(req, "ret_col", ret_col, col);
    chk(req, "ret_data_a", ret_data_a, da);
    chk(req, "ret_data_b", ret_data_b, db);
    chk(req, "ret_mask_a", ret_mask_a, ma);
    chk(req, "ret_mask_b", ret_mask_b, mb);
  endtask

  task automatic t_reset();
    chk("R1", "ret_we", ret_we, 0);
    chk("R1", "rd_en", rd_en, 0);
    chk("R1", "pre_banks", pre_banks, 0);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "ret_we after nocop", ret_we, 0);
    step();
  endtask

  task automatic t_basic_retire();
    issue(1, 3'd1, 1, 3, 5, 64'hA1A1, 64'hB1B1, 0, 0, 0);
    chk("R3", "empty retire on WR", ret_we, 0);
    step(); idle(8);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R2", 3, 5, 64'hA1A1, 64'hB1B1, 8'hFF, 8'hFF);
    step();
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3", "second retire empty", ret_we, 0);
    step();
  endtask

  task automatic t_wr_after_wr();
    issue(1, 3'd1, 1, 1, 2, 64'hC2, 64'hD2, 0, 0, 0);
    step(); idle(8);
    issue(1, 3'd1, 1, 4, 7, 64'hC3, 64'hD3, 0, 0, 0);
    chk_ret("R2", 1, 2, 64'hC2, 64'hD2, 8'hFF, 8'hFF);
    step(); idle(8);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R2", 4, 7, 64'hC3, 64'hD3, 8'hFF, 8'hFF);
    step();
  endtask

  task automatic t_read_block();
    issue(1, 3'd1, 1, 6, 8, 64'hE6, 64'hF6, 0, 0, 0);
    step(); idle(8);
    issue(1, 3'd2, 1, 9, 1, 0, 0, 0, 0, 0);
    chk("R5", "no retire on local RD", ret_we, 0);
    chk("R5", "rd_en", rd_en, 1);
    chk("R5", "rd_bank", rd_bank, 9);
    chk("R5", "rd_col", rd_col, 1);
    step();
    chk("R5", "no precharge after RD", pre_banks, 0);
    issue(1, 3'd5, 1, 11, 2, 0, 0, 0, 0, 0);
    chk("R11", "no retire on local RDA", ret_we, 0);
    chk("R11", "rd_en on RDA", rd_en, 1);
    chk("R11", "no precharge yet", pre_banks, 0);
    step();
    chk("R11", "RDA precharge", pre_banks, NB'(1) << 11);
    issue(1, 3'd2, 0, 20, 3, 0, 0, 0, 0, 0);
    chk_ret("R4", 6, 8, 64'hE6, 64'hF6, 8'hFF, 8'hFF);
    chk("R4", "foreign RD no read", rd_en, 0);
    step();
  endtask

  task automatic t_foreign();
    issue(1, 3'd1, 0, 2, 2, 64'h77, 64'h88, 0, 0, 0);
    chk("R4", "foreign WR empty", ret_we, 0);
    step();
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "foreign WR did not load", ret_we, 0);
    step();
    issue(1, 3'd1, 1, 13, 4, 64'h13, 64'h31, 0, 0, 0);
    step();
    issue(1, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R4", 13, 4, 64'h13, 64'h31, 8'hFF, 8'hFF);
    step();
  endtask

  task automatic t_mask();
    issue(1, 3'd1, 1, 5, 3, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, 0, 0, 0);
    step(); idle(8);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 1, 8'h0F, 8'hA5);
    chk_ret("R6", 5, 3, 64'h1122334455667788, 64'h99AABBCCDDEEFF00, 8'h0F, 8'hA5);
    step();
    issue(1, 3'd1, 1, 14, 9, 64'h5A, 64'hA5, 0, 0, 0);
    step(); idle(8);
    issue(1, 3'd2, 1, 1, 1, 0, 0, 1, 8'h33, 8'hCC);
    chk("R6", "blocked by RD", ret_we, 0);
    step();
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R6", 14, 9, 64'h5A, 64'hA5, 8'h33, 8'hCC);
    step();
  endtask

  task automatic t_mask_empty();
    issue(1, 3'd0, 1, 0, 0, 0, 0, 1, 8'h00, 8'h00);
    chk("R7", "mask on empty", ret_we, 0);
    step();
    issue(1, 3'd1, 1, 2, 9, 64'h21, 64'h12, 0, 0, 0);
    step(); idle(8);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R7", 2, 9, 64'h21, 64'h12, 8'hFF, 8'hFF);
    step();
  endtask

  task automatic t_prec();
    issue(1, 3'd3, 1, 3, 0, 0, 0, 0, 0, 0);
    chk("R9", "PREC empty no retire", ret_we, 0);
    step();
    chk("R9", "PREC empty precharge", pre_banks, NB'(1) << 3);
    issue(1, 3'd1, 1, 7, 6, 64'h70, 64'h07, 0, 0, 0);
    step(); idle(8);
    issue(1, 3'd3, 1, 12, 0, 0, 0, 0, 0, 0);
    chk_ret("R9", 7, 6, 64'h70, 64'h07, 8'hFF, 8'hFF);
    chk("R9", "precharge not before retire", pre_banks, 0);
    step();
    chk("R9", "PREC precharge", pre_banks, NB'(1) << 12);
  endtask

  task automatic t_wra();
    issue(1, 3'd4, 1, 10, 4, 64'hAA10, 64'hBB10, 0, 0, 0);
    chk("R10", "WRA empty no retire", ret_we, 0);
    step();
    chk("R10", "WRA no early precharge", pre_banks, 0);
    idle(8);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R10", 10, 4, 64'hAA10, 64'hBB10, 8'hFF, 8'hFF);
    chk("R10", "precharge after strobe only", pre_banks, 0);
    step();
    chk("R10", "WRA precharge", pre_banks, NB'(1) << 10);
  endtask

  task automatic t_no_effect();
    issue(1, 3'd1, 1, 8, 8, 64'h88, 64'h99, 0, 0, 0);
    step();
    issue(0, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R12", "invalid cycle no retire", ret_we, 0);
    step();
    issue(1, 3'd6, 1, 1, 1, 0, 0, 0, 0, 0);
    chk("R12", "reserved op no retire", ret_we, 0);
    chk("R12", "reserved op no read", rd_en, 0);
    step();
    chk("R12", "reserved op no precharge", pre_banks, 0);
    issue(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk_ret("R12", 8, 8, 64'h88, 64'h99, 8'hFF, 8'hFF);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_hit = 1'b0; cmd_op = 3'd0;
    cmd_bank = '0; cmd_col = '0; wr_data_a = '0; wr_data_b = '0;
    mask_valid = 1'b0; mask_a = '0; mask_b = '0;
    idle(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic_retire();
    t_wr_after_wr();
    t_read_block();
    t_foreign();
    t_mask();
    t_mask_empty();
    t_prec();
    t_wra();
    t_no_effect();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule